// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

The block keeps a running calendar: seconds, minutes, hours (24-hour), day of month, month, two-digit year and a weekday index. All fields except the weekday are packed BCD bytes and are stepped directly in BCD, with no binary form kept alongside them. The calendar advances by one second on each cycle where an external one-second tick arrives while the run control is high.

Each advance produces one-cycle event pulses: one for the second, and one each for the minute, hour and day boundaries that the step crosses. An alarm compares the freshly stepped calendar against six alarm inputs (seconds through year). When all six agree it raises a one-cycle match pulse.

The time is set through a parallel load port. The load port writes all seven fields in one cycle, but only while the counter is stopped.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the calendar reads 00:00:00, day 01, month 01, year 00, weekday 0, and all event and alarm pulses are low.
- R2: A tick while run is high advances the seconds by one, visible in the next cycle, and raises the second pulse in that same cycle. Seconds go from 59 to 00 and raise the minute pulse.
- R3: Minutes go from 59 to 00 on a seconds wrap and raise the hour pulse. Hours go from 23 to 00 on a minutes wrap and raise the day pulse.
- R4: The weekday (values 0 to 6) advances together with the day of month and goes from 6 back to 0.
- R5: The day of month returns to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02.
- R6: In month 02 the day returns to 01 after 29 when the binary value of the year is divisible by 4 (00 counts), and after 28 otherwise.
- R7: Month goes from 12 to 01 and then steps the year. Year goes from 99 to 00.
- R8: While run is low, ticks have no effect: every field holds and no pulse is raised.
- R9: A load while run is low writes all seven fields from the load inputs, visible in the next cycle. A load while run is high is ignored.
- R10: The alarm pulse rises for one cycle, in the cycle after an advancing tick, when the new seconds, minutes, hours, day, month and year all equal the alarm inputs. The weekday takes no part in the match, and a load that sets a matching time raises no alarm.
- R11: Every event and alarm pulse lasts exactly one cycle per advancing tick and is low in cycles that follow no advancing tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-second strobe from the prescaler |
| run | input | 1 | Counting enable |
| load | input | 1 | Write all load fields (honoured only while stopped) |
| ld_sec | input | 8 | Seconds to load, BCD |
| ld_min | input | 8 | Minutes to load, BCD |
| ld_hour | input | 8 | Hours to load, BCD |
| ld_day | input | 8 | Day of month to load, BCD |
| ld_mon | input | 8 | Month to load, BCD 01..12 |
| ld_year | input | 8 | Year to load, BCD 00..99 |
| ld_wday | input | 3 | Weekday to load, 0..6 |
| al_sec | input | 8 | Alarm seconds, BCD |
| al_min | input | 8 | Alarm minutes, BCD |
| al_hour | input | 8 | Alarm hours, BCD |
| al_day | input | 8 | Alarm day of month, BCD |
| al_mon | input | 8 | Alarm month, BCD |
| al_year | input | 8 | Alarm year, BCD |
| sec | output | 8 | Current seconds, BCD |
| min | output | 8 | Current minutes, BCD |
| hour | output | 8 | Current hours, BCD |
| day | output | 8 | Current day of month, BCD |
| mon | output | 8 | Current month, BCD |
| year | output | 8 | Current year, BCD |
| wday | output | 3 | Current weekday |
| ev_sec | output | 1 | Second boundary pulse |
| ev_min | output | 1 | Minute boundary pulse |
| ev_hour | output | 1 | Hour boundary pulse |
| ev_day | output | 1 | Day boundary pulse |
| alarm_hit | output | 1 | Alarm match pulse |

## Verification
Every result of this block is due exactly one cycle after the edge that samples its cause. This covers the stepped fields, the load, the four boundary pulses and the alarm pulse, which is computed from the next-state values rather than a cycle later. The bench drives inputs on falling edges and runs its behavioural calendar on the rising edge that the design sees. It compares every output on the following falling edge, so each comparison lands in the cycle the result is due and fails on any early, late or stretched pulse.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_day,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  input  logic [2:0] ld_wday,
  input  logic [7:0] al_sec,
  input  logic [7:0] al_min,
  input  logic [7:0] al_hour,
  input  logic [7:0] al_day,
  input  logic [7:0] al_mon,
  input  logic [7:0] al_year,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] day,
  output logic [7:0] mon,
  output logic [7:0] year,
  output logic [2:0] wday,
  output logic       ev_sec,
  output logic       ev_min,
  output logic       ev_hour,
  output logic       ev_day,
  output logic       alarm_hit
);

  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] base);
    if (v == top) return base;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  logic       adv, c_min, c_hour, c_day, c_mon, c_year, leap;
  logic [7:0] year_bin, last_day;
  logic [7:0] n_sec, n_min, n_hour, n_day, n_mon, n_year;
  logic       match;

  assign adv      = run & tick;
  assign c_min    = adv & (sec == 8'h59);
  assign c_hour   = c_min & (min == 8'h59);
  assign c_day    = c_hour & (hour == 8'h23);
  assign c_mon    = c_day & (day == last_day);
  assign c_year   = c_mon & (mon == 8'h12);

  assign year_bin = {4'd0, year[7:4]} * 8'd10 + {4'd0, year[3:0]};
  assign leap     = (year_bin[1:0] == 2'b00);

  always_comb begin
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign n_sec  = adv    ? bcd_step(sec,  8'h59, 8'h00)    : sec;
  assign n_min  = c_min  ? bcd_step(min,  8'h59, 8'h00)    : min;
  assign n_hour = c_hour ? bcd_step(hour, 8'h23, 8'h00)    : hour;
  assign n_day  = c_day  ? bcd_step(day,  last_day, 8'h01) : day;
  assign n_mon  = c_mon  ? bcd_step(mon,  8'h12, 8'h01)    : mon;
  assign n_year = c_year ? bcd_step(year, 8'h99, 8'h00)    : year;

  assign match = {n_sec, n_min, n_hour, n_day, n_mon, n_year} ==
                 {al_sec, al_min, al_hour, al_day, al_mon, al_year};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= 8'h00; min <= 8'h00; hour <= 8'h00;
      day <= 8'h01; mon <= 8'h01; year <= 8'h00; wday <= 3'd0;
      ev_sec <= 1'b0; ev_min <= 1'b0; ev_hour <= 1'b0; ev_day <= 1'b0;
      alarm_hit <= 1'b0;
    end else begin
      ev_sec    <= adv;
      ev_min    <= c_min;
      ev_hour   <= c_hour;
      ev_day    <= c_day;
      alarm_hit <= adv & match;
      if (adv) begin
        sec <= n_sec; min <= n_min; hour <= n_hour;
        day <= n_day; mon <= n_mon; year <= n_year;
        if (c_day) wday <= (wday == 3'd6) ? 3'd0 : wday + 3'd1;
      end else if (load && !run) begin
        sec <= ld_sec; min <= ld_min; hour <= ld_hour;
        day <= ld_day; mon <= ld_mon; year <= ld_year; wday <= ld_wday;
      end
    end
  end

  // R2
  sec_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sec |-> $past(tick && run));

  // R3
  carry_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_min |-> ev_sec) and (ev_hour |-> ev_min) and (ev_day |-> ev_hour));

  // R8
  hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable({sec, min, hour, day, mon, year, wday}) && !ev_sec);

  // R10
  alarm_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> ev_sec && {sec, min, hour, day, mon, year} ==
      $past({al_sec, al_min, al_hour, al_day, al_mon, al_year}));

  // R11
  alarm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> !alarm_hit || ev_sec);

endmodule

// File: tb/bcd_calendar_bench.sv
`timescale 1ns/1ps
module bcd_calendar_bench;
  localparam real HALF = 2.5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, run = 1'b0, load = 1'b0;
  logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_day = 8'h01, ld_mon = 8'h01, ld_year = 0;
  logic [2:0] ld_wday = 0;
  logic [7:0] al_sec = 0, al_min = 0, al_hour = 0, al_day = 8'h01, al_mon = 8'h01, al_year = 8'h77;
  logic [7:0] sec, min, hour, day, mon, year;
  logic [2:0] wday;
  logic ev_sec, ev_min, ev_hour, ev_day, alarm_hit;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit armed = 0;

  bcd_calendar u_bcd_calendar (.*);

  always #(HALF) clk = ~clk;

  function automatic int unbcd(logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic logic [7:0] tobcd(int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction
  function automatic int days_in(int m, int y);
    case (m)
      2: return (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  int ms, mm, mh, md, mmo, my, mw;
  bit es, em, eh, ed, ea;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; mw = 0;
      es = 0; em = 0; eh = 0; ed = 0; ea = 0;
    end else begin
      es = 0; em = 0; eh = 0; ed = 0; ea = 0;
      if (run && tick) begin
        es = 1; ms++;
        if (ms == 60) begin
          ms = 0; em = 1; mm++;
          if (mm == 60) begin
            mm = 0; eh = 1; mh++;
            if (mh == 24) begin
              mh = 0; ed = 1; mw = (mw + 1) % 7; md++;
              if (md > days_in(mmo, my)) begin
                md = 1; mmo++;
                if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
              end
            end
          end
        end
        ea = (ms == unbcd(al_sec)) && (mm == unbcd(al_min)) && (mh == unbcd(al_hour)) &&
             (md == unbcd(al_day)) && (mmo == unbcd(al_mon)) && (my == unbcd(al_year));
      end else if (load && !run) begin
        ms = unbcd(ld_sec); mm = unbcd(ld_min); mh = unbcd(ld_hour);
        md = unbcd(ld_day); mmo = unbcd(ld_mon); my = unbcd(ld_year); mw = int'(ld_wday);
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) if (armed) begin
    chk("calendar", {8'h0, sec, min, hour, day, mon, year, 5'h0, wday},
        {8'h0, tobcd(ms), tobcd(mm), tobcd(mh), tobcd(md), tobcd(mmo), tobcd(my), 5'h0, 3'(mw)});
    chk("events", {59'h0, ev_sec, ev_min, ev_hour, ev_day, alarm_hit}, {59'h0, es, em, eh, ed, ea});
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(1); tick = 1'b0; cyc(gap);
    end
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s, logic [7:0] d,
                          logic [7:0] mo, logic [7:0] y, logic [2:0] w);
    run = 1'b0; cyc(1);
    ld_hour = h; ld_min = m; ld_sec = s; ld_day = d; ld_mon = mo; ld_year = y; ld_wday = w;
    load = 1'b1; cyc(1); load = 1'b0; cyc(1);
  endtask

  initial begin
    cyc(2); armed = 1; cyc(1);
    rst_n = 1'b1; cyc(2);
    // R1 reset values compared by the running checks above
    phase = "R2"; run = 1'b1; ticks(65, 1);
    phase = "R11"; ticks(10, 0); cyc(3);
    phase = "R3"; set_time(8'h23, 8'h59, 8'h58, 8'h30, 8'h04, 8'h23, 3'd6);
    run = 1'b1; ticks(3, 1);
    phase = "R4"; set_time(8'h23, 8'h59, 8'h59, 8'h10, 8'h07, 8'h23, 3'd5);
    run = 1'b1; ticks(1, 2); set_time(8'h23, 8'h59, 8'h59, 8'h11, 8'h07, 8'h23, 3'd6);
    run = 1'b1; ticks(1, 2);
    phase = "R5"; set_time(8'h23, 8'h59, 8'h59, 8'h31, 8'h01, 8'h23, 3'd1);
    run = 1'b1; ticks(1, 1); set_time(8'h23, 8'h59, 8'h59, 8'h30, 8'h11, 8'h23, 3'd2);
    run = 1'b1; ticks(1, 1); set_time(8'h23, 8'h59, 8'h59, 8'h30, 8'h10, 8'h23, 3'd2);
    run = 1'b1; ticks(1, 1);
    phase = "R6"; set_time(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h23, 3'd0);
    run = 1'b1; ticks(1, 1); set_time(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h24, 3'd0);
    run = 1'b1; ticks(1, 1); set_time(8'h23, 8'h59, 8'h59, 8'h29, 8'h02, 8'h24, 3'd1);
    run = 1'b1; ticks(1, 1); set_time(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h00, 3'd1);
    run = 1'b1; ticks(1, 1);
    phase = "R7"; set_time(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99, 3'd3);
    run = 1'b1; ticks(1, 1); set_time(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h45, 3'd3);
    run = 1'b1; ticks(1, 1);
    phase = "R8"; run = 1'b0; ticks(5, 1); run = 1'b1; ticks(2, 1);
    phase = "R9"; set_time(8'h12, 8'h34, 8'h56, 8'h17, 8'h08, 8'h19, 3'd4);
    run = 1'b1; ld_hour = 8'h01; ld_min = 8'h02; ld_sec = 8'h03; ld_wday = 3'd0;
    load = 1'b1; cyc(3); load = 1'b0; ticks(2, 1);
    phase = "R10";
    al_hour = 8'h10; al_min = 8'h20; al_sec = 8'h33; al_day = 8'h15; al_mon = 8'h06; al_year = 8'h25;
    set_time(8'h10, 8'h20, 8'h30, 8'h15, 8'h06, 8'h25, 3'd2);
    run = 1'b1; ticks(6, 1);
    set_time(8'h10, 8'h20, 8'h33, 8'h15, 8'h06, 8'h25, 3'd2); cyc(3);
    run = 1'b0; ticks(2, 1);
    set_time(8'h10, 8'h20, 8'h32, 8'h15, 8'h06, 8'h25, 3'd5);
    run = 1'b1; ticks(2, 0); cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(HALF * 2 * 20000);
    errors++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule